// File: doc/BRIEF.md
# Match-Compare Watchdog with Third-Miss Reset

This block is a watchdog built on a free-running 16-bit up-counter. The counter advances only on cycles where a slow-clock strobe is high and the block is enabled. Whenever the count equals a programmed compare value, the block records a match event, sets a sticky status flag and, if the mask allows it, raises an interrupt. A match never restarts the count. The counter wraps from 65535 to 0, so the same compare value matches once per full period. Software can shorten that period by excluding some of the counter's upper bits from the compare.

Software services the watchdog by writing 1 to the status flag. That write also forgets any earlier unserviced match events. If software leaves the flag set while two match events go by, the third match event produces a one-cycle reset request. After the request, the counter, the status flag and the miss tally all return to zero. A lock bit protects the enable, compare and ignore-bits settings from stray writes.

The miss tally is an escalation state machine with four states:
- CLEAN: no unserviced match.
- ONE_MISS: one unserviced match.
- TWO_MISS: two unserviced matches.
- FIRE: the reset request is being issued.

It moves between them as follows:
- Advance: a match event moves CLEAN to ONE_MISS, ONE_MISS to TWO_MISS, and TWO_MISS to FIRE.
- Service: a status clear returns ONE_MISS or TWO_MISS to CLEAN.
- Drop: while the block is disabled, every state goes to CLEAN.
- Finish: FIRE always returns to CLEAN on the next cycle.

Top module: `wdt_match_guard`

## Requirements
- R1: After reset, all registers read 0, the block is unlocked and disabled, and `irq` and `rst_req` are low.
- R2: The count (address 6, read only) rises by 1 at each clock edge where `tick`=1 and enable (address 0 bit 0) is 1. It wraps from 65535 to 0 and holds otherwise.
- R3: A match event happens at an edge where `tick`=1, enable=1 and `(count ^ match) & (16'hFFFF >> ign)` is zero. Here match is address 2 bits [15:0] and ign is address 3 bits [3:0]. A written ign above 12 is stored as 12. A match does not alter the count, so with ign=0 a match value is hit exactly once in every 65536 ticks.
- R4: The status flag (address 4 bit 0) is set by a match event. A write with bit 0 = 1 clears it, and a write with bit 0 = 0 has no effect. When a clear and a match event fall on the same edge, the flag ends up set.
- R5: `irq` equals the status flag ANDed with the mask bit (address 5 bit 0).
- R6: The third match event since the last clear (or since enabling) puts the machine in FIRE. `rst_req` is then high for exactly the one cycle after that edge. Events advance the tally whether or not the interrupt is masked.
- R7: A status clear resets the tally to CLEAN, and so does a cycle with enable=0. If a match event falls on the same edge as a clear, the tally counts that one event.
- R8: The lock bit (address 1 bit 0) is always writable. While it is 1, writes to addresses 0, 2 and 3 are discarded.
- R9: At the edge that ends the `rst_req` cycle, the count and the status flag become 0. Enable, lock, match, ign and mask keep their values.
- R10: `rdata` shows, combinationally, the register selected by `addr`. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow-clock count strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| irq | output | 1 | Masked match interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The assertions assume that `wr_en`, `addr`, `wdata` and `tick` are stable across each clock edge and are never X once reset is released. The bench ensures this by changing every input only on the falling edge. The checks that the count holds or steps also take `tick` to be a plain strobe rather than a clock. The bench drives it as a level that it changes at most once per cycle. Stimulus aimed at the corners (clear and match on the same edge, writes while locked, a full 65536-tick wrap) is timed from the bench's own model of the count, so it never relies on the design's internal state.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int CNT_W   = 16;
    localparam int IGN_MAX = 12;
    localparam int IGN_W   = $clog2(IGN_MAX + 1);
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LOCK  = 3'd1;
    localparam logic [ADDR_W-1:0] A_MATCH = 3'd2;
    localparam logic [ADDR_W-1:0] A_IGN   = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_MASK  = 3'd5;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd6;

    typedef enum logic [1:0] {
        ESC_CLEAN = 2'd0,
        ESC_ONE   = 2'd1,
        ESC_TWO   = 2'd2,
        ESC_FIRE  = 2'd3
    } esc_state_t;
endpackage

// File: rtl/wdt_regfile.sv
`timescale 1ns/1ps
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int W      = CNT_W,
    parameter int IGW    = IGN_W,
    parameter int IGMAX  = IGN_MAX,
    parameter int AW     = ADDR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [W-1:0]   wdata,
    input  logic [W-1:0]   cnt,
    input  logic           status,
    output logic           en,
    output logic           lock,
    output logic           mask_on,
    output logic [W-1:0]   match_val,
    output logic [IGW-1:0] ign,
    output logic           clr,
    output logic [W-1:0]   rdata
);
    localparam logic [IGW-1:0] IGN_TOP = IGW'(IGMAX);

    logic [IGW-1:0] ign_wr;
    logic           wr_open;

    always_comb begin
        ign_wr  = (wdata[IGW-1:0] > IGN_TOP) ? IGN_TOP : wdata[IGW-1:0];
        wr_open = wr_en && !lock;
        clr     = wr_en && (addr == A_STAT) && wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en        <= 1'b0;
            lock      <= 1'b0;
            mask_on   <= 1'b0;
            match_val <= '0;
            ign       <= '0;
        end else begin
            if (wr_en && addr == A_LOCK) lock    <= wdata[0];
            if (wr_en && addr == A_MASK) mask_on <= wdata[0];
            if (wr_open && addr == A_CTRL)  en        <= wdata[0];
            if (wr_open && addr == A_MATCH) match_val <= wdata;
            if (wr_open && addr == A_IGN)   ign       <= ign_wr;
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = {{(W-1){1'b0}}, en};
            A_LOCK:  rdata = {{(W-1){1'b0}}, lock};
            A_MATCH: rdata = match_val;
            A_IGN:   rdata = {{(W-IGW){1'b0}}, ign};
            A_STAT:  rdata = {{(W-1){1'b0}}, status};
            A_MASK:  rdata = {{(W-1){1'b0}}, mask_on};
            A_COUNT: rdata = cnt;
            default: rdata = '0;
        endcase
    end

    // R8
    lock_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock && addr == A_MATCH) |=> $stable(match_val));
    // R8
    lock_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock && addr == A_CTRL) |=> $stable(en));
    // R3
    ign_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ign <= IGN_TOP);
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int W   = CNT_W,
    parameter int IGW = IGN_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           tick,
    input  logic           fire,
    input  logic [W-1:0]   match_val,
    input  logic [IGW-1:0] ign,
    output logic [W-1:0]   cnt,
    output logic           evt
);
    logic [W-1:0] keep;
    logic         step;

    always_comb begin
        keep = {W{1'b1}} >> ign;
        step = en && tick;
        evt  = step && !fire && (((cnt ^ match_val) & keep) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (fire) cnt <= '0;
        else if (step) cnt <= cnt + 1'b1;
    end

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !fire) |=> $stable(cnt));
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !fire) |=> (cnt == W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/wdt_escalate.sv
`timescale 1ns/1ps
module wdt_escalate
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic evt,
    input  logic clr,
    output logic status,
    output logic fire
);
    esc_state_t state, state_nx, base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ESC_CLEAN;
        else        state <= state_nx;
    end

    always_comb begin
        base     = clr ? ESC_CLEAN : state;
        state_nx = state;
        unique case (state)
            ESC_FIRE: state_nx = ESC_CLEAN;
            default: begin
                if (!en) begin
                    state_nx = ESC_CLEAN;
                end else if (evt) begin
                    unique case (base)
                        ESC_CLEAN: state_nx = ESC_ONE;
                        ESC_ONE:   state_nx = ESC_TWO;
                        default:   state_nx = ESC_FIRE;
                    endcase
                end else if (clr) begin
                    state_nx = ESC_CLEAN;
                end
            end
        endcase
    end

    always_comb begin
        fire = (state == ESC_FIRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    status <= 1'b0;
        else if (fire) status <= 1'b0;
        else if (evt)  status <= 1'b1;
        else if (clr)  status <= 1'b0;
    end

    // R6
    fire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fire) |-> $past(state == ESC_TWO && evt));
    // R6
    fire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    // R4
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> status);
    // R7
    clr_tally_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> (state == ESC_CLEAN));
endmodule

// File: rtl/wdt_match_guard.sv
`timescale 1ns/1ps
module wdt_match_guard
    import wdt_pkg::*;
#(
    parameter int W     = CNT_W,
    parameter int IGMAX = IGN_MAX,
    parameter int AW    = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          irq,
    output logic          rst_req
);
    localparam int IGW = $clog2(IGMAX + 1);

    logic           en, lock, mask_on, clr, status, fire, evt;
    logic [W-1:0]   match_val, cnt;
    logic [IGW-1:0] ign;

    wdt_regfile #(.W(W), .IGW(IGW), .IGMAX(IGMAX), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt(cnt), .status(status), .en(en), .lock(lock), .mask_on(mask_on),
        .match_val(match_val), .ign(ign), .clr(clr), .rdata(rdata)
    );

    wdt_counter #(.W(W), .IGW(IGW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .fire(fire),
        .match_val(match_val), .ign(ign), .cnt(cnt), .evt(evt)
    );

    wdt_escalate u_esc (
        .clk(clk), .rst_n(rst_n), .en(en), .evt(evt), .clr(clr),
        .status(status), .fire(fire)
    );

    always_comb begin
        irq     = status && mask_on;
        rst_req = fire;
    end

    // R9
    after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (cnt == '0 && !status));
    // R9
    fire_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !wr_en) |=> ($stable(match_val) && $stable(ign) && $stable(en)));
endmodule

// File: tb/sim_wdt_match_guard.sv
`timescale 1ns/1ps
module sim_wdt_match_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        irq, rst_req;

    int checks = 0, errors = 0, rst_seen = 0;
    bit done = 0;
    string ph = "R1";

    // reference model state
    int m_cnt, m_status, m_tally, m_fire, m_en, m_lock, m_match, m_ign, m_mask;

    always #2 clk = ~clk;

    wdt_match_guard u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req));

    function automatic int m_read(input int a);
        case (a)
            0: return m_en;
            1: return m_lock;
            2: return m_match;
            3: return m_ign;
            4: return m_status;
            5: return m_mask;
            6: return m_cnt;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_status = 0; m_tally = 0; m_fire = 0;
            m_en = 0; m_lock = 0; m_match = 0; m_ign = 0; m_mask = 0;
        end else begin
            int keep, evt, clr, nt, nf;
            keep = 16'hFFFF >> m_ign;
            evt  = (!m_fire && m_en && tick && ((m_cnt & keep) == (m_match & keep))) ? 1 : 0;
            clr  = (wr_en && addr == 3'd4 && wdata[0]) ? 1 : 0;
            nf = 0;
            nt = m_tally;
            if (m_fire || !m_en) nt = 0;
            else begin
                if (clr) nt = 0;
                if (evt) nt = nt + 1;
                if (nt == 3) begin nt = 0; nf = 1; end
            end
            if (m_fire) m_status = 0;
            else if (evt) m_status = 1;
            else if (clr) m_status = 0;
            if (m_fire) m_cnt = 0;
            else if (m_en && tick) m_cnt = (m_cnt + 1) % 65536;
            if (wr_en) begin
                if (addr == 3'd1) m_lock = wdata[0];
                if (addr == 3'd5) m_mask = wdata[0];
                if (!m_lock && addr == 3'd0) m_en = wdata[0];
                if (!m_lock && addr == 3'd2) m_match = wdata;
                if (!m_lock && addr == 3'd3) m_ign = (wdata[3:0] > 12) ? 12 : wdata[3:0];
            end
            m_tally = nt;
            m_fire = nf;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", tag, ph, act, exp);
        end
    endtask

    task automatic compare();
        chk(irq, m_status & m_mask, "R5 irq");
        chk(rst_req, m_fire, "R6 rst_req");
        chk(rdata, m_read(addr), "R10 rdata");
        if (rst_req) rst_seen++;
    endtask

    task automatic step(input bit t, input bit w, input int a, input int d);
        tick = t; wr_en = w; addr = a[2:0]; wdata = d[15:0];
        @(negedge clk);
        compare();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R2 watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int r0, c0, rises, prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        ph = "R1";
        for (int a = 0; a < 8; a++) begin
            step(0, 0, a, 0);
            chk(rdata, 0, "R1 reset value");
            chk(irq | rst_req, 0, "R1 outputs low");
        end

        ph = "R3";
        step(0, 1, 3, 15);
        step(0, 0, 3, 0);
        chk(rdata, 12, "R3 ignore clamp");
        step(0, 1, 2, 3);
        step(0, 1, 5, 1);
        step(0, 1, 0, 1);

        ph = "R4";
        for (int i = 0; i < 40; i++) begin
            step(1, 0, 4, 0);
            if (irq) break;
        end
        chk(irq, 1, "R5 irq raised on match");
        step(1, 1, 4, 0);
        chk(rdata[0], 1, "R4 write of zero ignored");
        step(1, 1, 4, 1);
        chk(irq, 0, "R4 clear by write one");

        ph = "R4 same edge";
        for (int i = 0; i < 40; i++) begin
            if ((m_cnt % 16) == 3) break;
            step(1, 0, 6, 0);
        end
        step(1, 1, 4, 1);
        chk(irq, 1, "R4 match beats clear");

        ph = "R6";
        r0 = rst_seen;
        for (int i = 0; i < 60; i++) begin
            step(1, 0, 6, 0);
            if (rst_req) break;
        end
        chk(rst_req, 1, "R6 reset on third miss");
        step(0, 0, 6, 0);
        chk(rst_req, 0, "R6 single cycle");
        chk(rdata, 0, "R9 count cleared");

        ph = "R9";
        step(0, 0, 2, 0); chk(rdata, 3, "R9 match kept");
        step(0, 0, 3, 0); chk(rdata, 12, "R9 ignore kept");
        step(0, 0, 4, 0); chk(rdata, 0, "R9 status cleared");
        step(0, 0, 0, 0); chk(rdata, 1, "R9 enable kept");

        ph = "R5 masked";
        step(0, 1, 5, 0);
        r0 = rst_seen;
        for (int i = 0; i < 70; i++) begin
            step(1, 0, 4, 0);
            chk(irq, 0, "R5 masked irq low");
            if (rst_req) break;
        end
        chk(rst_seen - r0, 1, "R6 escalation while masked");
        step(0, 1, 5, 1);

        ph = "R7";
        r0 = rst_seen;
        for (int i = 0; i < 100; i++) begin
            if (irq) step(1, 1, 4, 1);
            else     step(1, 0, 4, 0);
        end
        chk(rst_seen - r0, 0, "R7 serviced never resets");
        step(1, 1, 4, 1);
        for (int i = 0; i < 60; i++) begin
            if (m_tally == 2) break;
            step(1, 0, 6, 0);
        end
        step(0, 1, 0, 0);
        step(0, 1, 0, 1);
        for (int i = 0; i < 60; i++) begin
            if (m_tally == 2) break;
            step(1, 0, 6, 0);
        end
        for (int i = 0; i < 5; i++) step(1, 0, 6, 0);
        chk(rst_seen - r0, 0, "R7 disable clears tally");
        step(0, 1, 4, 1);

        ph = "R2";
        for (int i = 0; i < 20; i++) step(i % 2, 0, 6, 0);
        c0 = rdata;
        for (int i = 0; i < 5; i++) step(0, 0, 6, 0);
        chk(rdata, c0, "R2 hold without tick");
        step(0, 1, 0, 0);
        for (int i = 0; i < 5; i++) step(1, 0, 6, 0);
        chk(rdata, c0, "R2 hold while disabled");
        step(0, 1, 0, 1);
        step(0, 1, 4, 1);

        ph = "R8";
        step(0, 1, 1, 1);
        step(0, 1, 2, 9);
        step(0, 1, 3, 0);
        step(0, 1, 0, 0);
        step(0, 0, 2, 0); chk(rdata, 3, "R8 match write discarded");
        step(0, 0, 3, 0); chk(rdata, 12, "R8 ignore write discarded");
        step(0, 0, 0, 0); chk(rdata, 1, "R8 enable write discarded");
        step(0, 1, 1, 0);
        step(0, 1, 2, 9);
        step(0, 0, 2, 0); chk(rdata, 9, "R8 unlocked write");

        ph = "R3 wrap";
        step(0, 1, 3, 0);
        step(0, 1, 2, 5);
        step(0, 1, 4, 1);
        step(0, 0, 6, 0);
        c0 = rdata;
        rises = 0;
        prev = irq;
        for (int i = 0; i < 65536; i++) begin
            if (irq) step(1, 1, 4, 1);
            else     step(1, 0, 4, 0);
            if (irq && !prev) rises++;
            prev = irq;
        end
        step(0, 0, 6, 0);
        chk(rises, 1, "R3 one match per 65536 ticks");
        chk(rdata, c0, "R2 wrap period 65536");

        done = 1;
        summary();
        $finish;
    end
endmodule